// File: doc/BRIEF.md
# In-Order Load Response Buffer

This block sits between a global memory load pipeline and the register writeback stage. Every load that the pipeline issues is given a sequence number and a slot in a small ring of entries. Memory may answer those loads in any order; each answer marks its own slot as complete and stores the returned word there. Writeback only ever receives the oldest outstanding load, and only once that load's answer has come back, so results leave in the order the loads were issued.

A mode input switches the block to a second path. On that path the ordering is bypassed and answers are handed to writeback in the order they came back, through a separate first-in first-out queue. The buffer holds `DEPTH` entries (16 by default) and refuses new issues while all of them are outstanding. Sequence numbers are one bit wider than a slot index, so a full ring and an empty ring are told apart.

The block has two states. `ST_ORDERED` (mode input 0) delivers in issue order; `ST_ARRIVAL` (mode input 1) delivers in arrival order. The transition ordered-to-arrival is taken at a clock edge where the mode input is 1 and nothing is outstanding; arrival-to-ordered is taken at an edge where the mode input is 0 and nothing is outstanding. Reset enters `ST_ORDERED`.

Top module: `resp_order_buf`

## Requirements
- R1: Each accepted issue (`iss_valid` high while `iss_ready` is high at a clock edge) is given the sequence number shown on `iss_seq` in that cycle; the first after reset is 0 and each later one is the previous plus 1, wrapping modulo 2*DEPTH.
- R2: After reset `iss_ready` is 1 and `ret_valid` is 0; `iss_ready` is 0 exactly while DEPTH issued loads have not yet been delivered, and an issue attempted then is ignored (the next accepted issue still gets the next number).
- R3: In the ordered state a response may name any outstanding sequence number; its data is stored with it, and a load is delivered only when it is the oldest outstanding one and its response has arrived, carrying that response's data on `ret_data`.
- R4: In the ordered state the sequence numbers on `ret_seq` appear in strictly ascending issue order, each exactly once.
- R5: Delivery is registered: a response sampled at clock edge k for the oldest load appears on `ret_valid`/`ret_seq`/`ret_data` after edge k+1, and at most one load is delivered per cycle, so already-completed younger loads follow on consecutive cycles.
- R6: An issue and a delivery can occur at the same edge; after a delivery from a full buffer `iss_ready` returns to 1 in the following cycle.
- R7: In the arrival state each response is delivered, with its own sequence number and data, in the order responses arrived, with the same two-edge latency as R5.
- R8: A change of `mode_arrival` takes effect only at a clock edge where no loads are outstanding; while loads are outstanding the current delivery order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_arrival | input | 1 | 0 = deliver in issue order, 1 = deliver in arrival order |
| iss_valid | input | 1 | Pipeline issues a load this cycle |
| iss_ready | output | 1 | A slot is free for an issue |
| iss_seq | output | SEQ_W (5) | Sequence number given to an issue this cycle |
| rsp_valid | input | 1 | Memory returns a response this cycle |
| rsp_seq | input | SEQ_W (5) | Sequence number of the returning load |
| rsp_data | input | DATA_W (32) | Returned data word |
| ret_valid | output | 1 | A load is delivered to writeback this cycle |
| ret_seq | output | SEQ_W (5) | Sequence number of the delivered load |
| ret_data | output | DATA_W (32) | Data of the delivered load |

## Verification
Sequence numbers and `iss_ready` come straight from registers, so they are checked in the same cycle the issue is driven, and a blocked `iss_ready` is expected to rise one edge after the delivery that frees a slot. A response sampled at edge k is due on the delivery outputs only after edge k+1, so the directed cases look for `ret_valid` low one cycle after the response and high the cycle after that, then for the waiting younger loads on the next consecutive cycles. Inputs change and outputs are sampled on the falling edge, half a period away from the edge that moves the registers, and a reference queue in the bench (filled at issue in ordered mode, at response in arrival mode) predicts every delivered number and word during the random phases.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [0:0] {
        ST_ORDERED = 1'b0,
        ST_ARRIVAL = 1'b1
    } rob_mode_e;

endpackage

// File: rtl/rob_seq_ctrl.sv
module rob_seq_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int SEQ_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_arrival,
    input  logic             iss_valid,
    input  logic             ret_fire,
    output logic             iss_ready,
    output logic             iss_fire,
    output logic             empty,
    output logic [SEQ_W-1:0] head,
    output logic [SEQ_W-1:0] tail,
    output rob_mode_e        state_q
);

    rob_mode_e        state_d;
    logic [SEQ_W-1:0] head_q;
    logic [SEQ_W-1:0] tail_q;
    logic [SEQ_W-1:0] count;
    logic             full;

    // state and pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ORDERED;
            head_q  <= '0;
            tail_q  <= '0;
        end else begin
            state_q <= state_d;
            if (iss_fire) tail_q <= tail_q + SEQ_W'(1);
            if (ret_fire) head_q <= head_q + SEQ_W'(1);
        end
    end

    // next-state: mode changes only while nothing is outstanding
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ORDERED: if (mode_arrival && empty)  state_d = ST_ARRIVAL;
            ST_ARRIVAL: if (!mode_arrival && empty) state_d = ST_ORDERED;
            default:    state_d = ST_ORDERED;
        endcase
    end

    // outputs
    always_comb begin
        count     = tail_q - head_q;
        empty     = (count == '0);
        full      = (count == SEQ_W'(DEPTH));
        iss_ready = !full;
        iss_fire  = iss_valid && !full;
        head      = head_q;
        tail      = tail_q;
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= SEQ_W'(DEPTH));

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !empty |=> state_q == $past(state_q));

    assert_no_ret_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fire |-> !empty);

endmodule

// File: rtl/rob_order_store.sv
module rob_order_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);

    logic [DEPTH-1:0]  done_q;
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  hit_wr;
    logic [DEPTH-1:0]  hit_clr;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_dec
        assign hit_wr[gi]  = wr_en  && (wr_idx  == IDX_W'(gi));
        assign hit_clr[gi] = clr_en && (clr_idx == IDX_W'(gi));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hit_wr[i])       done_q[i] <= 1'b1;
                else if (hit_clr[i]) done_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_wr[i]) data_q[i] <= wr_data;
        end
    end

    assign rd_done = done_q[rd_idx];
    assign rd_data = data_q[rd_idx];

    assert_retire_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> done_q[clr_idx]);

endmodule

// File: rtl/rob_arrival_fifo.sv
module rob_arrival_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 37,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         empty,
    output logic [W-1:0] head_data
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr_q;
    logic [PTR_W-1:0] rptr_q;
    logic             full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push) wptr_q <= wptr_q + PTR_W'(1);
            if (pop)  rptr_q <= rptr_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr_q[IDX_W-1:0]] <= push_data;
    end

    assign empty     = (wptr_q == rptr_q);
    assign full      = (wptr_q[IDX_W-1:0] == rptr_q[IDX_W-1:0]) &&
                       (wptr_q[IDX_W] != rptr_q[IDX_W]);
    assign head_data = mem[rptr_q[IDX_W-1:0]];

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/resp_order_buf.sv
module resp_order_buf
    import rob_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int SEQ_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_arrival,
    input  logic              iss_valid,
    output logic              iss_ready,
    output logic [SEQ_W-1:0]  iss_seq,
    input  logic              rsp_valid,
    input  logic [SEQ_W-1:0]  rsp_seq,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              ret_valid,
    output logic [SEQ_W-1:0]  ret_seq,
    output logic [DATA_W-1:0] ret_data
);

    localparam int FIFO_W = SEQ_W + DATA_W;

    rob_mode_e         state_q;
    logic              iss_fire;
    logic              empty;
    logic [SEQ_W-1:0]  head;
    logic [SEQ_W-1:0]  tail;
    logic              ret_fire;
    logic              ord_ret;
    logic              arr_ret;
    logic              head_done;
    logic [DATA_W-1:0] head_word;
    logic              fifo_empty;
    logic [FIFO_W-1:0] fifo_head;
    logic              ord_wr;
    logic              arr_push;

    logic              ret_valid_q;
    logic [SEQ_W-1:0]  ret_seq_q;
    logic [DATA_W-1:0] ret_data_q;

    rob_seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_arrival (mode_arrival),
        .iss_valid    (iss_valid),
        .ret_fire     (ret_fire),
        .iss_ready    (iss_ready),
        .iss_fire     (iss_fire),
        .empty        (empty),
        .head         (head),
        .tail         (tail),
        .state_q      (state_q)
    );

    assign ord_wr   = rsp_valid && (state_q == ST_ORDERED);
    assign arr_push = rsp_valid && (state_q == ST_ARRIVAL);

    rob_order_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ord_wr),
        .wr_idx  (rsp_seq[IDX_W-1:0]),
        .wr_data (rsp_data),
        .clr_en  (ord_ret),
        .clr_idx (head[IDX_W-1:0]),
        .rd_idx  (head[IDX_W-1:0]),
        .rd_done (head_done),
        .rd_data (head_word)
    );

    rob_arrival_fifo #(.DEPTH(DEPTH), .W(FIFO_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (arr_push),
        .push_data ({rsp_seq, rsp_data}),
        .pop       (arr_ret),
        .empty     (fifo_empty),
        .head_data (fifo_head)
    );

    // retire selection: oldest-and-done, or arrival head
    always_comb begin
        ord_ret = 1'b0;
        arr_ret = 1'b0;
        unique case (state_q)
            ST_ORDERED: ord_ret = !empty && head_done;
            ST_ARRIVAL: arr_ret = !fifo_empty;
            default: ;
        endcase
        ret_fire = ord_ret || arr_ret;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_valid_q <= 1'b0;
            ret_seq_q   <= '0;
            ret_data_q  <= '0;
        end else begin
            ret_valid_q <= ret_fire;
            if (ord_ret) begin
                ret_seq_q  <= head;
                ret_data_q <= head_word;
            end else if (arr_ret) begin
                ret_seq_q  <= fifo_head[FIFO_W-1:DATA_W];
                ret_data_q <= fifo_head[DATA_W-1:0];
            end
        end
    end

    assign iss_seq   = tail;
    assign ret_valid = ret_valid_q;
    assign ret_seq   = ret_seq_q;
    assign ret_data  = ret_data_q;

    assert_one_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ord_ret && arr_ret));

    assert_order_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ord_wr && !empty) |-> ((rsp_seq - head) < (tail - head)));

endmodule

// File: tb/sim_resp_order_buf.sv
module sim_resp_order_buf;

    localparam int DEPTH  = 16;
    localparam int DATA_W = 32;
    localparam int SEQ_W  = 5;
    localparam int NSEQ   = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_arrival = 1'b0;
    logic              iss_valid = 1'b0;
    logic              iss_ready;
    logic [SEQ_W-1:0]  iss_seq;
    logic              rsp_valid = 1'b0;
    logic [SEQ_W-1:0]  rsp_seq = '0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic              ret_valid;
    logic [SEQ_W-1:0]  ret_seq;
    logic [DATA_W-1:0] ret_data;

    always #10 clk = ~clk;

    resp_order_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_arrival(mode_arrival),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_seq(iss_seq),
        .rsp_valid(rsp_valid), .rsp_seq(rsp_seq), .rsp_data(rsp_data),
        .ret_valid(ret_valid), .ret_seq(ret_seq), .ret_data(ret_data)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model
    bit                b_arrival = 1'b0;
    logic [SEQ_W-1:0]  exp_next = '0;
    logic [SEQ_W-1:0]  eq_seq [64];
    logic [DATA_W-1:0] eq_data [64];
    int                eq_rd = 0;
    int                eq_wr = 0;
    logic [DATA_W-1:0] data_by_seq [NSEQ];
    logic [SEQ_W-1:0]  pend [NSEQ];
    int                npend = 0;
    int                n_issued = 0;
    int                n_ret = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [SEQ_W-1:0] seq_after(input logic [SEQ_W-1:0] s);
        return s + SEQ_W'(1);
    endfunction

    // delivery monitor
    always @(negedge clk) begin
        if (rst_n && ret_valid) begin
            if (eq_rd == eq_wr) begin
                check(1'b0, "R4", "unexpected delivery seq", ret_seq, 0);
            end else begin
                logic [SEQ_W-1:0]  es;
                logic [DATA_W-1:0] ed;
                es = eq_seq[eq_rd % 64];
                ed = b_arrival ? eq_data[eq_rd % 64] : data_by_seq[es];
                check(ret_seq == es, b_arrival ? "R7" : "R4", "delivered seq", ret_seq, es);
                check(ret_data == ed, b_arrival ? "R7" : "R3", "delivered data", ret_data, ed);
                eq_rd++;
            end
            n_ret++;
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 100000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic drop_pend(input int k);
        pend[k] = pend[npend-1];
        npend--;
    endtask

    // one cycle of drive; want_rsp picks a pending load by index
    task automatic drive(input bit want_iss, input bit want_rsp, input int pick,
                         input logic [DATA_W-1:0] d);
        logic [SEQ_W-1:0] s;
        @(negedge clk);
        iss_valid = 1'b0;
        rsp_valid = 1'b0;
        if (want_rsp && npend > 0) begin
            int k;
            k = pick % npend;
            s = pend[k];
            drop_pend(k);
            rsp_valid = 1'b1;
            rsp_seq   = s;
            rsp_data  = d;
            data_by_seq[s] = d;
            if (b_arrival) begin
                eq_seq[eq_wr % 64]  = s;
                eq_data[eq_wr % 64] = d;
                eq_wr++;
            end
        end
        if (want_iss && iss_ready) begin
            check(iss_seq == exp_next, "R1", "issued seq", iss_seq, exp_next);
            iss_valid = 1'b1;
            pend[npend] = iss_seq;
            npend++;
            if (!b_arrival) begin
                eq_seq[eq_wr % 64] = iss_seq;
                eq_wr++;
            end
            exp_next = seq_after(exp_next);
            n_issued++;
        end
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 0, '0);
    endtask

    // respond to a named sequence number
    task automatic respond(input logic [SEQ_W-1:0] s, input logic [DATA_W-1:0] d,
                           input bit also_iss);
        int k;
        k = 0;
        for (int i = 0; i < npend; i++) if (pend[i] == s) k = i;
        drive(also_iss, 1'b1, k, d);
    endtask

    task automatic drain(input string req);
        while (npend > 0) drive(1'b0, 1'b1, int'($urandom % 8), $urandom);
        for (int i = 0; i < 40 && eq_rd != eq_wr; i++) idle();
        idle();
        check(eq_rd == eq_wr, req, "undelivered loads after drain", eq_wr - eq_rd, 0);
    endtask

    task automatic random_run(input int cycles);
        for (int i = 0; i < cycles; i++)
            drive(($urandom % 4) != 0, ($urandom % 3) != 0, int'($urandom % 32), $urandom);
    endtask

    logic [SEQ_W-1:0] base;

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        @(negedge clk);
        check(iss_ready == 1'b1, "R2", "ready after reset", iss_ready, 1);
        check(ret_valid == 1'b0, "R2", "ret_valid after reset", ret_valid, 0);
        check(iss_seq == '0, "R1", "first seq", iss_seq, 0);

        // R3/R5: younger done loads wait for the oldest
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 0, '0);
        respond(5'd2, 32'hA2, 1'b0);
        respond(5'd1, 32'hA1, 1'b0);
        for (int i = 0; i < 4; i++) begin
            idle();
            check(ret_valid == 1'b0, "R3", "delivery while oldest pending", ret_valid, 0);
        end
        respond(5'd0, 32'hA0, 1'b0);
        idle();
        check(ret_valid == 1'b0, "R5", "delivery one edge after response", ret_valid, 0);
        idle();
        check(ret_valid && ret_seq == 5'd0, "R5", "oldest delivered after two edges", ret_seq, 0);
        idle();
        check(ret_valid && ret_seq == 5'd1, "R5", "next consecutive delivery", ret_seq, 1);
        idle();
        check(ret_valid && ret_seq == 5'd2, "R5", "third consecutive delivery", ret_seq, 2);
        idle();
        check(ret_valid == 1'b0, "R5", "no delivery after last", ret_valid, 0);

        // R2/R6: fill, blocked issue, free a slot, issue with delivery
        base = exp_next;
        for (int i = 0; i < DEPTH; i++) drive(1'b1, 1'b0, 0, '0);
        idle();
        check(iss_ready == 1'b0, "R2", "ready when full", iss_ready, 0);
        @(negedge clk);
        iss_valid = 1'b1;
        @(negedge clk);
        iss_valid = 1'b0;
        check(iss_seq == exp_next, "R2", "issue while full ignored", iss_seq, exp_next);
        respond(base, 32'hB0, 1'b0);
        idle();
        check(iss_ready == 1'b0, "R6", "ready before delivery", iss_ready, 0);
        idle();
        check(iss_ready == 1'b1, "R6", "ready after delivery from full", iss_ready, 1);
        respond(seq_after(base), 32'hB1, 1'b1);
        idle();
        check(iss_ready == 1'b0, "R6", "full again after issue", iss_ready, 0);
        idle();
        check(ret_valid && ret_seq == seq_after(base), "R6", "delivery while full", ret_seq, seq_after(base));
        drain("R4");

        // R8: mode change deferred while loads are outstanding
        base = exp_next;
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 0, '0);
        mode_arrival = 1'b1;
        respond(base + SEQ_W'(2), 32'hC2, 1'b0);
        respond(base + SEQ_W'(1), 32'hC1, 1'b0);
        respond(base, 32'hC0, 1'b0);
        idle();
        idle();
        check(ret_valid && ret_seq == base, "R8", "issue order kept after mode change", ret_seq, base);
        drain("R8");
        idle();
        idle();
        b_arrival = 1'b1;

        // R7: arrival order
        base = exp_next;
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 0, '0);
        respond(base + SEQ_W'(2), 32'hD2, 1'b0);
        respond(base, 32'hD0, 1'b0);
        check(ret_valid == 1'b0, "R7", "delivery one edge after response", ret_valid, 0);
        respond(base + SEQ_W'(1), 32'hD1, 1'b0);
        check(ret_valid && ret_seq == base + SEQ_W'(2), "R7", "first arrival delivered", ret_seq, base + SEQ_W'(2));
        idle();
        check(ret_valid && ret_seq == base, "R7", "second arrival delivered", ret_seq, base);
        idle();
        check(ret_valid && ret_seq == base + SEQ_W'(1), "R7", "third arrival delivered", ret_seq, base + SEQ_W'(1));
        random_run(2500);
        drain("R7");

        // R8: back to ordered is also deferred
        base = exp_next;
        for (int i = 0; i < 2; i++) drive(1'b1, 1'b0, 0, '0);
        mode_arrival = 1'b0;
        respond(base + SEQ_W'(1), 32'hE1, 1'b0);
        idle();
        idle();
        check(ret_valid && ret_seq == base + SEQ_W'(1), "R8", "arrival order kept after mode change", ret_seq, base + SEQ_W'(1));
        drain("R8");
        idle();
        idle();
        b_arrival = 1'b0;

        random_run(2500);
        drain("R4");
        check(n_ret == n_issued, "R4", "every issued load delivered once", n_ret, n_issued);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule